// File: doc/BRIEF.md
# I2S Mono Channel Duplicator

This block takes a 64-bit-per-frame I2S stream and rebuilds it so that both halves of every output frame carry one chosen channel. A downstream stereo converter or processor then sees the same channel on left and right. Each half-frame holds 32 bit clocks. Word select is low for the left half and high for the right half, and the left half comes first. As is usual for I2S, word select changes one bit clock before each MSB.

A serial delay line runs on the same rising bit-clock edge that the downstream device uses to sample data, so it behaves like an extension of that device's input shift register. The delay line offers taps that lag the live data by one half-frame, one frame and one and a half frames. An output multiplexer picks one tap for each half-frame. There are two modes. In plain mode, selecting right pairs the previous period's right sample with the current one. In coherent mode, the output runs one frame late, so both halves of an output frame come from the same sample period. The channel selection and the mode are synchronised to the bit clock and are loaded only at the start of a frame.

Top module: `i2s_dup_top`

## Requirements
- R1: `ws_o` equals `ws_i` as sampled two rising bit-clock edges earlier, so the one-bit offset between word select and the MSB survives at the output (low = left half, high = right half).
- R2: Plain mode with left selected (`coherent_i`=0, `right_sel_i`=0): output frame n carries the left sample of input frame n in both halves.
- R3: Plain mode with right selected: output frame n carries the right sample of input frame n-1 in its left half and the right sample of input frame n in its right half.
- R4: Coherent mode with left selected: output frame n carries the left sample of input frame n-1 in both halves.
- R5: Coherent mode with right selected: output frame n carries the right sample of input frame n-1 in both halves.
- R6: Every output data bit is registered on the rising bit-clock edge, two edges after the input bit was sampled, which is the same latency as word select.
- R7: Any delayed bit that would reach back beyond the number of rising edges seen since reset is output as 0, even if the delay line still holds older data.
- R8: `right_sel_i` and `coherent_i` pass through a two-stage synchroniser and are loaded only when the first bit of a left half reaches the multiplexer. A change made mid-frame therefore leaves that frame unchanged and takes effect from the next frame.
- R9: While `rst_n` is low, `sd_o` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ws_i | input | 1 | Input word select (0 = left half, 1 = right half) |
| sd_i | input | 1 | Input serial data, MSB first, changed on the falling edge |
| right_sel_i | input | 1 | Static channel choice: 0 = left, 1 = right |
| coherent_i | input | 1 | Static mode: 1 = one-frame-delayed coherent output |
| ws_o | output | 1 | Output word select, aligned to `sd_o` |
| sd_o | output | 1 | Output serial data with the duplicated channel |

## Verification
Data and word select both emerge two rising edges after they are sampled. The bench therefore compares `ws_o`, read at each falling edge, with the `ws_i` value it read one falling edge earlier. Output words are rebuilt from `ws_o`: each word consists of the 32 bits that follow a word-select transition, and it is complete at the sample where the next transition appears. The bench pushes the expected pair for frame n into a queue when it starts driving input frame n, and the queue order matches the output order one to one. Selection changes are made halfway through the left half of a chosen frame. The words of that frame must still match the old mode, and the words of the following frame must match the new mode.

// File: rtl/i2s_dup_pkg.sv
// Shared types for the mono channel duplicator.
// Assumes four taps: live, half-frame, one-frame and one-and-a-half-frame lag.
package i2s_dup_pkg;

    localparam int NUM_TAPS = 4;

    typedef enum logic [1:0] {
        TAP_LIVE       = 2'd0,
        TAP_HALF       = 2'd1,
        TAP_FRAME      = 2'd2,
        TAP_FRAME_HALF = 2'd3
    } tap_e;

    // Choose the tap for one output bit from the mode, the selection and the half it belongs to.
    function automatic tap_e pick_tap(input logic coherent, input logic right_sel,
                                      input logic right_half);
        case ({coherent, right_sel})
            2'b00:   return right_half ? TAP_HALF       : TAP_LIVE;
            2'b01:   return right_half ? TAP_LIVE       : TAP_HALF;
            2'b10:   return right_half ? TAP_FRAME_HALF : TAP_FRAME;
            default: return right_half ? TAP_FRAME      : TAP_HALF;
        endcase
    endfunction

endpackage

// File: rtl/i2s_dup_mode_ctrl.sv
// Synchronises the channel selection and the mode to the bit clock and loads
// them only at a frame boundary. The loaded value is forwarded in the boundary
// cycle itself, so the first bit of a frame already uses the new setting.
// Assumes both inputs are quasi-static (they change rarely and are slow
// compared with the frame rate).
module i2s_dup_mode_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic right_sel_i,
    input  logic coherent_i,
    input  logic frame_start_i,
    output logic right_sel_o,
    output logic coherent_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sel_sync;
    logic [TOP:0] coh_sync;
    logic         sel_q;
    logic         coh_q;

    // Bring the asynchronous settings into the bit-clock domain.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            sel_sync <= '0;
            coh_sync <= '0;
        end else begin
            sel_sync <= {sel_sync[TOP-1:0], right_sel_i};
            coh_sync <= {coh_sync[TOP-1:0], coherent_i};
        end
    end

    // Hold the active setting and reload it only on the first bit of a frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            coh_q <= 1'b0;
        end else if (frame_start_i) begin
            sel_q <= sel_sync[TOP];
            coh_q <= coh_sync[TOP];
        end
    end

    assign right_sel_o = frame_start_i ? sel_sync[TOP] : sel_q;
    assign coherent_o  = frame_start_i ? coh_sync[TOP] : coh_q;

    // R8: the active setting never moves away from a frame boundary
    assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
        !frame_start_i |=> ($stable(sel_q) && $stable(coh_q)));

    // R8: at a boundary the synchronised value becomes the active one
    assert_mode_load_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
        frame_start_i |=> (sel_q == $past(sel_sync[TOP]) && coh_q == $past(coh_sync[TOP])));

endmodule

// File: rtl/i2s_dup_delay.sv
// Serial delay line with taps spaced one half-frame apart. Each tap output is
// forced to 0 until enough bits have been shifted in since reset to fill that
// tap. The line does not shift during reset, so data left over from before the
// reset is never exposed.
// Assumes din_i is the registered input data bit.
module i2s_dup_delay
    import i2s_dup_pkg::*;
#(
    parameter int HALF_BITS = 32
) (
    input  logic                clk_i,
    input  logic                rst_n,
    input  logic                din_i,
    output logic [NUM_TAPS-1:0] tap_o,
    output logic [NUM_TAPS-1:0] valid_o
);
    localparam int DEPTH = (NUM_TAPS - 1) * HALF_BITS;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] line_q;
    logic [CW-1:0]    fill_q;

    // Shift the line on every rising edge outside reset.
    always_ff @(posedge clk_i) begin
        if (rst_n) line_q <= {line_q[DEPTH-2:0], din_i};
    end

    // Count the bits shifted in since reset, saturating at the line depth.
    always_ff @(posedge clk_i) begin
        if (!rst_n)                      fill_q <= '0;
        else if (fill_q != CW'(DEPTH))   fill_q <= fill_q + CW'(1);
    end

    assign tap_o[0]   = din_i;
    assign valid_o[0] = 1'b1;

    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
        localparam int LAG = k * HALF_BITS;
        assign valid_o[k] = (fill_q >= CW'(LAG));
        assign tap_o[k]   = valid_o[k] & line_q[LAG-1];
    end

    // R7: the fill count advances by one per edge until it saturates
    assert_fill_step_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        (fill_q != CW'(DEPTH)) |=> (fill_q == $past(fill_q) + CW'(1)));

    // R7: the fill count never runs past the line depth
    assert_fill_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        fill_q <= CW'(DEPTH));

endmodule

// File: rtl/i2s_dup_outmux.sv
// Output multiplexer and data register. It picks one delay-line tap for each
// bit and registers it on the same rising edge the downstream device uses.
// Assumes the tap choice is already stable in the cycle it is used.
module i2s_dup_outmux
    import i2s_dup_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic [NUM_TAPS-1:0] valid_i,
    input  tap_e                tap_sel_i,
    output logic                sd_o
);
    // Register the chosen tap; the output stays low during reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n) sd_o <= 1'b0;
        else        sd_o <= tap_i[tap_sel_i];
    end

    // R7: a tap that is not yet filled always produces a zero output bit
    assert_prime_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        !valid_i[tap_sel_i] |=> !sd_o);

endmodule

// File: rtl/i2s_dup_top.sv
// Mono channel duplicator for a 64-bit I2S frame. The input bits and word select
// are registered, the half each bit belongs to is worked out from the previous
// word-select sample, and one delay-line tap is chosen for each bit. Word select
// gets the same two-edge latency as the data.
// Assumes a continuous bit clock with exactly HALF_BITS clocks in each half-frame.
module i2s_dup_top
    import i2s_dup_pkg::*;
#(
    parameter int HALF_BITS   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic bclk_i,
    input  logic rst_n,
    input  logic ws_i,
    input  logic sd_i,
    input  logic right_sel_i,
    input  logic coherent_i,
    output logic ws_o,
    output logic sd_o
);
    logic                s_d;
    logic                s_w;
    logic                s_half;
    logic                s_half_prev;
    logic                frame_start;
    logic                sel_eff;
    logic                coh_eff;
    tap_e                tap_sel;
    logic [NUM_TAPS-1:0] taps;
    logic [NUM_TAPS-1:0] tap_valid;

    // Input capture and word-select pipeline (data path, not reset).
    always_ff @(posedge bclk_i) begin
        s_d         <= sd_i;
        s_w         <= ws_i;
        s_half      <= s_w;
        s_half_prev <= s_half;
        ws_o        <= s_w;
    end

    // The first bit of a left half follows a bit of a right half.
    assign frame_start = !s_half && s_half_prev;
    assign tap_sel     = pick_tap(coh_eff, sel_eff, s_half);

    i2s_dup_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk_i        (bclk_i),
        .rst_n        (rst_n),
        .right_sel_i  (right_sel_i),
        .coherent_i   (coherent_i),
        .frame_start_i(frame_start),
        .right_sel_o  (sel_eff),
        .coherent_o   (coh_eff)
    );

    i2s_dup_delay #(.HALF_BITS(HALF_BITS)) u_delay (
        .clk_i  (bclk_i),
        .rst_n  (rst_n),
        .din_i  (s_d),
        .tap_o  (taps),
        .valid_o(tap_valid)
    );

    i2s_dup_outmux u_mux (
        .clk_i    (bclk_i),
        .rst_n    (rst_n),
        .tap_i    (taps),
        .valid_i  (tap_valid),
        .tap_sel_i(tap_sel),
        .sd_o     (sd_o)
    );

    // R1/R6: output word select trails the input by exactly two edges
    assert_ws_align_R1: assert property (@(posedge bclk_i) disable iff (!rst_n)
        ws_o == $past(ws_i, 2));

endmodule

// File: tb/i2s_dup_top_bench.sv
module i2s_dup_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 32;

    logic bclk  = 1'b0;
    logic rst_n = 1'b0;
    logic ws_i  = 1'b1;
    logic sd_i  = 1'b0;
    logic sel_r = 1'b0;
    logic coh   = 1'b0;
    logic ws_o;
    logic sd_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    int          req_q[$];
    logic        lsb_q = 1'b0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    i2s_dup_top u_i2s_dup_top (
        .bclk_i     (bclk),
        .rst_n      (rst_n),
        .ws_i       (ws_i),
        .sd_i       (sd_i),
        .right_sel_i(sel_r),
        .coherent_i (coh),
        .ws_o       (ws_o),
        .sd_o       (sd_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one bit slot just after a falling edge.
    task automatic bit_out(input logic w, input logic d);
        @(negedge bclk);
        #1;
        ws_i = w;
        sd_i = d;
    endtask

    // Monitor: word-select latency check and word decoding from ws_o.
    logic        prev_ws_i = 1'b1;
    logic        prev_ws_o = 1'b1;
    logic        collecting = 1'b0;
    int          bitcnt = 0;
    logic [31:0] sr = '0;
    always @(negedge bclk) begin
        if (rst_n) chk(ws_o == prev_ws_i, "R1/R6 ws latency", 32'(ws_o), 32'(prev_ws_i));
        if (collecting) begin
            sr = {sr[30:0], sd_o};
            bitcnt++;
            if (bitcnt == HB) begin
                collecting = 1'b0;
                if (exp_q.size() != 0) begin
                    logic [31:0] e;
                    int          r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(sr == e, $sformatf("R%0d word", r), sr, e);
                end
            end
        end
        if (ws_o !== prev_ws_o) begin
            collecting = 1'b1;
            bitcnt     = 0;
        end
        prev_ws_o = ws_o;
        prev_ws_i = ws_i;
    end

    // Reset with data high (R9 check), then flush the input to zero and idle.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) bit_out(1'b1, 1'b1);
        chk(sd_o == 1'b0, "R9 reset output", 32'(sd_o), 32'd0);
        repeat (3) bit_out(1'b1, 1'b0);
        rst_n = 1'b1;
        repeat (8) bit_out(1'b1, 1'b0);
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input bit chg,
                              input bit nsel, input bit ncoh);
        logic [31:0] w;
        for (int h = 0; h < 2; h++) begin
            w = (h == 0) ? l : r;
            for (int b = 0; b < HB; b++) begin
                if (chg && h == 0 && b == 16) begin
                    sel_r = nsel;
                    coh   = ncoh;
                end
                if (b == 0) bit_out(h[0], lsb_q);
                else        bit_out(h[0], w[HB-b]);
            end
            lsb_q = w[0];
        end
    endtask

    // One phase: reset, frames with an optional mid-frame change, then drain.
    task automatic run_phase(input int nfr, input bit sel0, input bit coh0, input int chg_at,
                             input bit sel1, input bit coh1);
        logic [31:0] pl;
        logic [31:0] pr;
        logic [31:0] l;
        logic [31:0] r;
        logic [31:0] e0;
        logic [31:0] e1;
        bit          cs;
        bit          cc;
        int          req;
        sel_r = sel0;
        coh   = coh0;
        do_reset();
        pl    = '0;
        pr    = '0;
        lsb_q = 1'b0;
        for (int n = 0; n < nfr; n++) begin
            cs = (chg_at >= 0 && n > chg_at) ? sel1 : sel0;
            cc = (chg_at >= 0 && n > chg_at) ? coh1 : coh0;
            l  = (n == 0) ? 32'h8000_0001 : $urandom;
            r  = (n == 0) ? 32'h7FFF_FFFE : $urandom;
            case ({cc, cs})
                2'b00:   begin e0 = l;  e1 = l;  req = 2; end // R2
                2'b01:   begin e0 = pr; e1 = r;  req = 3; end // R3
                2'b10:   begin e0 = pl; e1 = pl; req = 4; end // R4
                default: begin e0 = pr; e1 = pr; req = 5; end // R5
            endcase
            if (n == 0 && (cc || cs)) req = 7;           // R7: nothing filled yet
            if (chg_at >= 0 && (n == chg_at || n == chg_at + 1)) req = 8; // R8
            exp_q.push_back(e0); req_q.push_back(req);
            exp_q.push_back(e1); req_q.push_back(req);
            send_frame(l, r, (n == chg_at), sel1, coh1);
            pl = l;
            pr = r;
        end
        bit_out(1'b0, lsb_q);
        repeat (40) bit_out(1'b0, 1'b0);
    endtask

    initial begin
        run_phase(6, 1'b0, 1'b0, 3, 1'b1, 1'b0);  // plain left, then plain right
        run_phase(5, 1'b0, 1'b1, 2, 1'b1, 1'b1);  // coherent left, then coherent right
        run_phase(4, 1'b1, 1'b0, -1, 1'b0, 1'b0); // plain right across reset
        run_phase(4, 1'b1, 1'b1, 1, 1'b0, 1'b0);  // coherent right, then plain left
        chk(exp_q.size() == 0, "R2 all words seen", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule